// File: doc/BRIEF.md
# Serial ADC Output Shift Interface

This block is the digital serial port of a 14-bit sampling converter. The host lowers chip-select, toggles a serial clock and reads the result on a single data output. The value read in a frame is always the conversion captured in the frame before it. A frame is complete after 18 falling clock edges. The final falling edge starts an acquisition window that must run out before the next frame begins.

The chip-select and serial clock pins are synchronised into a faster system clock, and their edges are detected there. The whole block therefore runs on one clock and can be synthesised. A stand-in conversion port presents a parallel 14-bit result, which the block captures when chip-select falls. The block reports whether the result queued for the next frame is valid. It also flags a frame that started before the acquisition window ended.

Top module: `sadc_serial_if`

## Requirements
- R1: While the synchronised chip-select is high, `sdo_oe` is 0 and `sdo` is 0.
- R2: After chip-select falls, and before any falling edge of the serial clock, `sdo` shows a single 0.
- R3: The first rising edge that follows the first falling edge of a frame puts the MSB of the queued result on `sdo`. Each later rising edge puts out the next lower bit.
- R4: Once all 14 result bits have been sent, every further rising edge in that frame puts out 0.
- R5: The result sent in a frame is the `conv_data` value captured when chip-select fell in the previous frame. The first frame after reset sends all zeros.
- R6: The 18th falling edge of a frame raises `acq_active` for `ACQ_CYCLES` system clocks. Any falling edges after the 18th are ignored.
- R7: If chip-select rises after fewer than 18 falling edges, `next_valid` goes to 0. It returns to 1 when a frame ends with all 18 edges. Its value after reset is 1.
- R8: If chip-select falls while `acq_active` is 1, `acq_violation` is 1 for that frame. The next chip-select fall that comes outside the acquisition window clears it.
- R9: Rising edges that come before the first falling edge of a frame shift nothing: `sdo` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous chip-select pin, active low |
| sclk_in | input | 1 | Asynchronous serial clock pin |
| conv_data | input | 14 | Parallel result from the stand-in conversion port |
| sdo | output | 1 | Serial data output, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the data pad |
| next_valid | output | 1 | The result queued for the next frame is valid |
| acq_active | output | 1 | Acquisition window is running |
| acq_violation | output | 1 | The current frame began inside the acquisition window |

## Verification
Every pin change takes effect on the third system clock edge after it: two synchroniser stages, then the register that acts on the detected edge. The bench changes pins on a falling clock edge and waits four full system clocks before it samples any output, again on a falling edge. A serial bit is read four clocks after its rising edge. The leading zero, `acq_violation` and the idle-state values are read four clocks after the chip-select change. `acq_active` is read four clocks after the 18th falling edge, which is well inside its 20-cycle window, and `next_valid` is read four clocks after chip-select rises.

// File: rtl/sadc_pkg.sv
// Package for the serial converter interface.
// Holds the shared pin-event type and the default sizes used by the modules.
package sadc_pkg;
    localparam int DEF_DATA_W     = 14;
    localparam int DEF_FRAME_CLKS = 18;
    localparam int DEF_ACQ_CYCLES = 20;
    localparam int DEF_SYNC_STG   = 2;

    // Synchronised pin level together with its one-cycle edge strobes.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_evt_t;
endpackage

// File: rtl/sadc_pin_sync.sv
// Pin synchroniser and edge detector.
// Passes an asynchronous pin through STAGES flops, then compares the result
// with its previous value to make one-cycle rise and fall strobes.
// Assumes the pin stays at each level for longer than STAGES+1 system clocks.
module sadc_pin_sync
    import sadc_pkg::*;
#(
    parameter int STAGES  = DEF_SYNC_STG,
    parameter bit RST_VAL = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    output pin_evt_t evt
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchroniser chain plus the register that holds the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    // Turn the synchronised level into edge strobes.
    always_comb begin
        evt.level = chain[STAGES-1];
        evt.rise  = chain[STAGES-1] & ~prev;
        evt.fall  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/sadc_frame_ctl.sv
// Frame controller.
// Counts serial-clock falling edges while a frame is open, saturating at
// FRAME_CLKS. Starts the acquisition timer on the last counted edge and
// flags a frame that opens while the timer is still running.
// Assumes a chip-select fall and a serial-clock fall never share a cycle.
module sadc_frame_ctl
    import sadc_pkg::*;
#(
    parameter int FRAME_CLKS = DEF_FRAME_CLKS,
    parameter int ACQ_CYCLES = DEF_ACQ_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_on,
    input  logic cs_fall,
    input  logic sclk_fall,
    output logic started,
    output logic frame_full,
    output logic acq_active,
    output logic acq_violation
);
    localparam int CNT_W = $clog2(FRAME_CLKS + 1);
    localparam int TMR_W = $clog2(ACQ_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CLKS);

    logic [CNT_W-1:0] fall_cnt;
    logic [TMR_W-1:0] acq_tmr;
    logic             last_edge;

    assign last_edge  = frame_on && sclk_fall && (fall_cnt == LAST - 1'b1);
    assign started    = (fall_cnt != '0);
    assign frame_full = (fall_cnt == LAST);
    assign acq_active = (acq_tmr != '0);

    // Falling-edge counter: cleared when a frame opens, saturates at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fall_cnt <= '0;
        else if (cs_fall)
            fall_cnt <= '0;
        else if (frame_on && sclk_fall && fall_cnt != LAST)
            fall_cnt <= fall_cnt + 1'b1;
    end

    // Acquisition timer: loaded on the last edge, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acq_tmr <= '0;
        else if (last_edge)
            acq_tmr <= TMR_W'(ACQ_CYCLES);
        else if (acq_tmr != '0)
            acq_tmr <= acq_tmr - 1'b1;
    end

    // Violation flag: decided again at every frame opening.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acq_violation <= 1'b0;
        else if (cs_fall)
            acq_violation <= acq_active;
    end

    always_ff @(posedge clk) begin
        assert_cnt_cap_R6: assert (!rst_n || fall_cnt <= LAST)
            else $error("fall counter passed the frame length");
    end

    assert_acq_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_edge |=> acq_active);

    assert_extra_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_full && sclk_fall && !cs_fall) |=> $stable(fall_cnt));

    assert_violation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && acq_active) |=> acq_violation);
endmodule

// File: rtl/sadc_shift_out.sv
// Output shifter.
// When a frame opens, the result queued by the previous frame moves into the
// shift register and a new result is taken from the conversion port.
// A bit is shifted out on each rising edge that comes after the frame's first
// falling edge, and zeros fill the register behind the data. When the frame
// closes, the queued result is marked valid only if the frame was complete.
module sadc_shift_out
    import sadc_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_on,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              started,
    input  logic              frame_full,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sdo_q,
    output logic              pend_ok
);
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] shreg;

    // Result queue: swapped at frame opening; cleared by reset so the first frame sends zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_data <= '0;
            shreg     <= '0;
        end else if (cs_fall) begin
            shreg     <= pend_data;
            pend_data <= conv_data;
        end else if (frame_on && sclk_rise && started) begin
            shreg     <= {shreg[DATA_W-2:0], 1'b0};
        end
    end

    // Serial output bit: leading zero at opening, data on qualified rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdo_q <= 1'b0;
        else if (cs_fall || !frame_on)
            sdo_q <= 1'b0;
        else if (sclk_rise && started)
            sdo_q <= shreg[DATA_W-1];
    end

    // Validity of the queued result, decided when the frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_ok <= 1'b1;
        else if (cs_rise)
            pend_ok <= frame_full;
    end

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_on |=> !sdo_q);

    assert_lead_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !sdo_q);

    assert_no_early_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_on && !started && !cs_fall) |=> $stable(shreg));

    assert_short_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !frame_full) |=> !pend_ok);
endmodule

// File: rtl/sadc_serial_if.sv
// Top level of the serial converter interface.
// Synchronises chip-select and the serial clock into clk, then drives the
// frame controller and the output shifter. The data pad is enabled only while
// the synchronised chip-select is low.
// Assumes clk runs at least eight times faster than the serial clock.
module sadc_serial_if
    import sadc_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int FRAME_CLKS = DEF_FRAME_CLKS,
    parameter int ACQ_CYCLES = DEF_ACQ_CYCLES,
    parameter int SYNC_STG   = DEF_SYNC_STG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_in,
    input  logic              sclk_in,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              next_valid,
    output logic              acq_active,
    output logic              acq_violation
);
    pin_evt_t cs_evt;
    pin_evt_t sclk_evt;
    logic     frame_on;
    logic     started;
    logic     frame_full;
    logic     sdo_q;

    sadc_pin_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .pin(cs_n_in), .evt(cs_evt));

    sadc_pin_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .pin(sclk_in), .evt(sclk_evt));

    assign frame_on = ~cs_evt.level;

    sadc_frame_ctl #(.FRAME_CLKS(FRAME_CLKS), .ACQ_CYCLES(ACQ_CYCLES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .frame_on(frame_on),
        .cs_fall(cs_evt.fall), .sclk_fall(sclk_evt.fall),
        .started(started), .frame_full(frame_full),
        .acq_active(acq_active), .acq_violation(acq_violation));

    sadc_shift_out #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .frame_on(frame_on),
        .cs_fall(cs_evt.fall), .cs_rise(cs_evt.rise), .sclk_rise(sclk_evt.rise),
        .started(started), .frame_full(frame_full), .conv_data(conv_data),
        .sdo_q(sdo_q), .pend_ok(next_valid));

    assign sdo    = sdo_q & frame_on;
    assign sdo_oe = frame_on;

    assert_pad_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);
endmodule

// File: tb/tb_sadc_serial_if.sv
module tb_sadc_serial_if;
    localparam int DW = 14;
    localparam int FC = 18;
    localparam int NV = 6;
    localparam logic [DW-1:0] VEC_DATA [NV] = '{14'h3A5C, 14'h1234, 14'h3FFF,
                                                 14'h0001, 14'h2AAA, 14'h0000};
    localparam int VEC_FALLS [NV] = '{18, 18, 18, 10, 18, 18};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_in = 1'b1;
    logic sclk_in = 1'b1;
    logic [DW-1:0] conv_data = '0;
    logic sdo, sdo_oe, next_valid, acq_active, acq_violation;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Expected-state model kept by the bench.
    logic [DW-1:0] prev_data = '0;

    // Values captured by the frame task.
    logic       lead_sdo, lead_oe, lead_viol, pre_rise_sdo, acq_seen, idle_oe, idle_sdo;
    logic [31:0] cap;

    sadc_serial_if dut (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
        .conv_data(conv_data), .sdo(sdo), .sdo_oe(sdo_oe),
        .next_valid(next_valid), .acq_active(acq_active),
        .acq_violation(acq_violation));

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait4();
        repeat (4) @(negedge clk);
    endtask

    // One frame: the first captured bit lands in cap[nf-1], the last in cap[0].
    task automatic run_frame(input logic [DW-1:0] cd, input int nf,
                             input bit idle_low, input int gap);
        conv_data = cd;
        cap = '0;
        if (idle_low) begin
            sclk_in = 1'b0;
            wait4();
        end
        cs_n_in = 1'b0;
        wait4();
        lead_sdo  = sdo;
        lead_oe   = sdo_oe;
        lead_viol = acq_violation;
        if (idle_low) begin
            sclk_in = 1'b1;
            wait4();
            pre_rise_sdo = sdo;
        end
        for (int i = 0; i < nf; i++) begin
            sclk_in = 1'b0;
            wait4();
            if (i == FC - 1) acq_seen = acq_active;
            sclk_in = 1'b1;
            wait4();
            cap = {cap[30:0], sdo};
        end
        cs_n_in = 1'b1;
        wait4();
        idle_oe  = sdo_oe;
        idle_sdo = sdo;
        repeat (gap) @(negedge clk);
    endtask

    // Expected serial word for nf rising edges: data MSB first, then zeros.
    function automatic logic [31:0] exp_word(input logic [DW-1:0] d, input int nf);
        logic [31:0] w = '0;
        for (int i = 0; i < nf; i++)
            w = {w[30:0], (i < DW) ? d[DW-1-i] : 1'b0};
        return w;
    endfunction

    // Per-frame checks shared by the table and the directed frames.
    task automatic frame_checks(input int nf, input logic [DW-1:0] expd);
        logic [31:0] ew = exp_word(expd, nf);
        int nd = (nf < DW) ? nf : DW;
        check("R2 leading zero", {31'b0, lead_sdo}, 32'd0);
        check("R2 pad enabled in frame", {31'b0, lead_oe}, 32'd1);
        check("R3 R5 data bits", cap >> (nf - nd), ew >> (nf - nd));
        if (nf > DW)
            check("R4 trailing zeros", cap & ((32'd1 << (nf - DW)) - 1), 32'd0);
        check("R7 next_valid after frame", {31'b0, next_valid}, {31'b0, (nf >= FC)});
        check("R1 pad idle", {30'b0, idle_oe, idle_sdo}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Reset state (R1, R7, R6, R8).
        check("R1 reset sdo_oe", {31'b0, sdo_oe}, 32'd0);
        check("R1 reset sdo", {31'b0, sdo}, 32'd0);
        check("R7 reset next_valid", {31'b0, next_valid}, 32'd1);
        check("R6 reset acq_active", {31'b0, acq_active}, 32'd0);
        check("R8 reset acq_violation", {31'b0, acq_violation}, 32'd0);

        // Table walk; the first frame after reset must send zeros (R5).
        for (int v = 0; v < NV; v++) begin
            run_frame(VEC_DATA[v], VEC_FALLS[v], 1'b0, 30);
            frame_checks(VEC_FALLS[v], prev_data);
            prev_data = VEC_DATA[v];
        end

        // R6: acquisition window opens on the 18th edge and has closed after the gap.
        run_frame(14'h3C3C, 18, 1'b0, 30);
        frame_checks(18, prev_data);
        check("R6 acq_active after last edge", {31'b0, acq_seen}, 32'd1);
        check("R6 acq_active ends", {31'b0, acq_active}, 32'd0);
        check("R8 no violation with gap", {31'b0, lead_viol}, 32'd0);
        prev_data = 14'h3C3C;

        // R9: serial clock idle low, a rising edge before any falling edge.
        run_frame(14'h1555, 18, 1'b1, 30);
        check("R9 early rise shifts nothing", {31'b0, pre_rise_sdo}, 32'd0);
        frame_checks(18, prev_data);
        prev_data = 14'h1555;

        // R8: the next frame opens inside the acquisition window.
        run_frame(14'h0F0F, 18, 1'b0, 0);
        frame_checks(18, prev_data);
        prev_data = 14'h0F0F;
        run_frame(14'h2222, 20, 1'b0, 30);
        check("R8 violation flagged", {31'b0, lead_viol}, 32'd1);
        // R6: falling edges 19 and 20 are ignored; only zeros follow the data.
        frame_checks(20, prev_data);
        prev_data = 14'h2222;
        run_frame(14'h0101, 18, 1'b0, 30);
        check("R8 violation cleared", {31'b0, lead_viol}, 32'd0);
        frame_checks(18, prev_data);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule